// File: doc/BRIEF.md
# Microprogram Sequencer with One-Level Return Register

This block chooses the next control-memory address for a microprogrammed control unit. On each clock it looks at three fields of the microinstruction being executed: a 2-bit test selector, a 2-bit branch kind and a 7-bit target address. It also looks at three status bits from the datapath and at the four opcode bits of the fetched instruction. From these it loads its control address register. The register's value goes straight out to address the control store. Alongside it, the block keeps a single return-address register for one level of micro-subroutine.

In a 20-bit microinstruction, the three micro-operation fields of 3 bits each come first. The test selector, the branch kind and the address follow them. The datapath decodes the micro-operation fields. The sequencer only receives the last three fields. Both registers change on the same clock edge that executes the current micro-operations. A synchronous reset starts fetch at microaddress 0.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the address register and the return register both become 0, so the address output reads 0 after that edge and a return taken right after reset goes to 0.
- R2: The test selector `cd_sel` picks the tested condition: 00 is always true, 01 is `dr_sign` (the indirect bit), 10 is `ac_sign` (the accumulator sign), and 11 is `ac_zero` (accumulator equal to zero).
- R3: With branch kind 00 (jump) and a true condition, the address register loads `ad_field`.
- R4: With branch kind 00 or 01 and a false condition, the address register becomes its old value plus one, modulo 128 (127 steps to 0).
- R5: With branch kind 01 (call) and a true condition, the address register loads `ad_field` and the return register loads the old address plus one, modulo 128.
- R6: With branch kind 01 and a false condition, the return register keeps its value.
- R7: With branch kind 10 (return), the address register loads the return register, whatever `cd_sel` and `ad_field` hold.
- R8: With branch kind 11 (map), address bits 5..2 load `dr_opcode[3:0]` and address bits 6, 1 and 0 become 0, whatever `cd_sel` and `ad_field` hold.
- R9: The return register holds a single entry, so a second taken call before a return replaces the earlier return address.
- R10: Jump, return and map leave the return register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cd_sel | input | 2 | Condition selector field of the current microinstruction |
| br_type | input | 2 | Branch kind: 00 jump, 01 call, 10 return, 11 map |
| ad_field | input | 7 | Branch target field of the current microinstruction |
| dr_sign | input | 1 | Bit 15 of the data register (indirect bit) |
| ac_sign | input | 1 | Bit 15 of the accumulator |
| ac_zero | input | 1 | High when the accumulator is all zeros |
| dr_opcode | input | 4 | Bits 14..11 of the data register, the instruction opcode |
| car | output | 7 | Current control address register, addressing the control store |

## Verification
On every cycle, the assertions check how each branch kind moves the address register. They cover the jump target, the wrapping increment, the return to the saved address and the map pattern. They also check that the return register is written only by a taken call, and that a taken call writes the old address plus one. The assertions also tie each selector code to its status input. What only the bench's scenarios show is behaviour over several steps: a return issued straight after reset, a nested call replacing the first return address, and map and jump leaving a pending return intact. Each of these is compared cycle by cycle against a behavioural model, including under random field and status patterns.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    TEST_ALWAYS  = 2'b00,
    TEST_DR_SIGN = 2'b01,
    TEST_AC_SIGN = 2'b10,
    TEST_AC_ZERO = 2'b11
  } test_sel_e;

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
  import useq_pkg::*;
(
  input  logic [1:0] cd_sel,
  input  logic       dr_sign,
  input  logic       ac_sign,
  input  logic       ac_zero,
  output logic       cond_true
);

  test_sel_e sel;
  assign sel = test_sel_e'(cd_sel);

  always_comb begin
    unique case (sel)
      TEST_ALWAYS:  cond_true = 1'b1;
      TEST_DR_SIGN: cond_true = dr_sign;
      TEST_AC_SIGN: cond_true = ac_sign;
      TEST_AC_ZERO: cond_true = ac_zero;
      default:      cond_true = 1'b1;
    endcase
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int OP_W    = 4,
  parameter int MAP_LSB = 2
) (
  input  logic [1:0]        br_type,
  input  logic              cond_true,
  input  logic [ADDR_W-1:0] ad_field,
  input  logic [ADDR_W-1:0] car_q,
  input  logic [ADDR_W-1:0] sbr_q,
  input  logic [OP_W-1:0]   dr_opcode,
  output logic [ADDR_W-1:0] car_d,
  output logic [ADDR_W-1:0] sbr_d,
  output logic              sbr_we,
  output logic              jump_taken,
  output logic              seq_step
);

  localparam int MAP_MSB = MAP_LSB + OP_W - 1;

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] map_addr;
  logic [ADDR_W-1:0] inc_addr;
  br_kind_e          kind;

  // Opcode placed into its window of the address; every other bit is zero.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_map_bit
    if (b >= MAP_LSB && b <= MAP_MSB) begin : g_op
      assign map_addr[b] = dr_opcode[b-MAP_LSB];
    end else begin : g_zero
      assign map_addr[b] = 1'b0;
    end
  end

  assign kind     = br_kind_e'(br_type);
  assign inc_addr = addr_inc(car_q);
  assign sbr_d    = inc_addr;

  always_comb begin
    car_d      = inc_addr;
    sbr_we     = 1'b0;
    jump_taken = 1'b0;
    seq_step   = 1'b0;
    unique case (kind)
      BR_JUMP, BR_CALL: begin
        if (cond_true) begin
          car_d      = ad_field;
          jump_taken = 1'b1;
          sbr_we     = (kind == BR_CALL);
        end else begin
          seq_step = 1'b1;
        end
      end
      BR_RET:  car_d = sbr_q;
      BR_MAP:  car_d = map_addr;
      default: car_d = inc_addr;
    endcase
  end

endmodule

// File: rtl/useq_state_regs.sv
module useq_state_regs #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] car_d,
  input  logic [ADDR_W-1:0] sbr_d,
  input  logic              sbr_we,
  output logic [ADDR_W-1:0] car_q,
  output logic [ADDR_W-1:0] sbr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q <= '0;
      sbr_q <= '0;
    end else begin
      car_q <= car_d;
      if (sbr_we) sbr_q <= sbr_d;
    end
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
  parameter int ADDR_W  = 7,
  parameter int OP_W    = 4,
  parameter int MAP_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cd_sel,
  input  logic [1:0]        br_type,
  input  logic [ADDR_W-1:0] ad_field,
  input  logic              dr_sign,
  input  logic              ac_sign,
  input  logic              ac_zero,
  input  logic [OP_W-1:0]   dr_opcode,
  output logic [ADDR_W-1:0] car
);

  logic              cond_true;
  logic              sbr_we;
  logic              jump_taken;
  logic              seq_step;
  logic [ADDR_W-1:0] car_d;
  logic [ADDR_W-1:0] sbr_d;
  logic [ADDR_W-1:0] car_q;
  logic [ADDR_W-1:0] sbr_q;

  useq_cond_mux u_cond (
    .cd_sel    (cd_sel),
    .dr_sign   (dr_sign),
    .ac_sign   (ac_sign),
    .ac_zero   (ac_zero),
    .cond_true (cond_true)
  );

  useq_next_addr #(
    .ADDR_W  (ADDR_W),
    .OP_W    (OP_W),
    .MAP_LSB (MAP_LSB)
  ) u_next (
    .br_type    (br_type),
    .cond_true  (cond_true),
    .ad_field   (ad_field),
    .car_q      (car_q),
    .sbr_q      (sbr_q),
    .dr_opcode  (dr_opcode),
    .car_d      (car_d),
    .sbr_d      (sbr_d),
    .sbr_we     (sbr_we),
    .jump_taken (jump_taken),
    .seq_step   (seq_step)
  );

  useq_state_regs #(
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .car_d  (car_d),
    .sbr_d  (sbr_d),
    .sbr_we (sbr_we),
    .car_q  (car_q),
    .sbr_q  (sbr_q)
  );

  assign car = car_q;

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int ADDR_W  = 7,
  parameter int OP_W    = 4,
  parameter int MAP_LSB = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cd_sel,
  input logic [1:0]        br_type,
  input logic [ADDR_W-1:0] ad_field,
  input logic              dr_sign,
  input logic              ac_sign,
  input logic              ac_zero,
  input logic [OP_W-1:0]   dr_opcode,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] sbr_q,
  input logic              cond_true,
  input logic              sbr_we,
  input logic              jump_taken,
  input logic              seq_step
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] car_plus;
  logic [ADDR_W-1:0] map_exp;
  assign car_plus = car + ONE;
  assign map_exp  = ADDR_W'(dr_opcode) << MAP_LSB;

  p_reset_r1: assert property (@(posedge clk) rst |=> (car == '0 && sbr_q == '0));

  p_cond_sel_r2: assert property (@(posedge clk) disable iff (rst)
    cond_true == ((cd_sel == 2'b00) || (cd_sel == 2'b01 && dr_sign) ||
                  (cd_sel == 2'b10 && ac_sign) || (cd_sel == 2'b11 && ac_zero)));

  p_jump_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (br_type[1] == 1'b0 && cond_true) |=> car == $past(ad_field));

  p_step_wraps_r4: assert property (@(posedge clk) disable iff (rst)
    (br_type[1] == 1'b0 && !cond_true) |=> car == $past(car_plus));

  p_call_saves_r5: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b01 && cond_true) |=> sbr_q == $past(car_plus));

  p_sbr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(br_type == 2'b01 && cond_true) |=> $stable(sbr_q));

  p_return_r7: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b10) |=> car == $past(sbr_q));

  p_map_r8: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b11) |=> car == $past(map_exp));

  p_events_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({jump_taken, seq_step}) && (!sbr_we || jump_taken));

endmodule

bind useq_sequencer useq_sequencer_chk #(
  .ADDR_W  (ADDR_W),
  .OP_W    (OP_W),
  .MAP_LSB (MAP_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cd_sel     (cd_sel),
  .br_type    (br_type),
  .ad_field   (ad_field),
  .dr_sign    (dr_sign),
  .ac_sign    (ac_sign),
  .ac_zero    (ac_zero),
  .dr_opcode  (dr_opcode),
  .car        (car),
  .sbr_q      (sbr_q),
  .cond_true  (cond_true),
  .sbr_we     (sbr_we),
  .jump_taken (jump_taken),
  .seq_step   (seq_step)
);

// File: tb/useq_sequencer_tb.sv
`timescale 1ns/1ps
module useq_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cd_sel = '0;
  logic [1:0] br_type = '0;
  logic [6:0] ad_field = '0;
  logic       dr_sign = 1'b0;
  logic       ac_sign = 1'b0;
  logic       ac_zero = 1'b0;
  logic [3:0] dr_opcode = '0;
  logic [6:0] car;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  int m_car = 0;
  int m_sbr = 0;

  always #2 clk = ~clk;

  useq_sequencer dut_i (
    .clk       (clk),
    .rst       (rst),
    .cd_sel    (cd_sel),
    .br_type   (br_type),
    .ad_field  (ad_field),
    .dr_sign   (dr_sign),
    .ac_sign   (ac_sign),
    .ac_zero   (ac_zero),
    .dr_opcode (dr_opcode),
    .car       (car)
  );

  task automatic check(input string tag, input int exp);
    n_checks++;
    if (int'(car) != exp) begin
      n_fails++;
      $display("FAIL %s: car=%0d expected=%0d", tag, car, exp);
    end
  endtask

  // One clock of the reference model, then compare after the edge.
  task automatic step(input bit r, input int cd, input int br, input int ad,
                      input bit ds, input bit as, input bit az, input int op,
                      input string tag);
    bit c;
    @(negedge clk);
    rst = r; cd_sel = 2'(cd); br_type = 2'(br); ad_field = 7'(ad);
    dr_sign = ds; ac_sign = as; ac_zero = az; dr_opcode = 4'(op);
    case (cd)
      0: c = 1;
      1: c = ds;
      2: c = as;
      default: c = az;
    endcase
    if (r) begin
      m_car = 0; m_sbr = 0;
    end else if (br == 0) begin
      m_car = c ? ad : (m_car + 1) % 128;
    end else if (br == 1) begin
      if (c) begin m_sbr = (m_car + 1) % 128; m_car = ad; end
      else m_car = (m_car + 1) % 128;
    end else if (br == 2) begin
      m_car = m_sbr;
    end else begin
      m_car = op * 4;
    end
    @(posedge clk);
    #1;
    check(tag, m_car);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: car=%0d expected=finish", car);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then a return straight away shows an empty return register
    step(1, 1, 1, 99, 1, 1, 1, 9, "R1");
    step(1, 0, 0, 55, 0, 0, 0, 0, "R1");
    step(0, 3, 2, 77, 0, 0, 1, 0, "R1");
    // R3 / R2: each condition source, taken and not taken
    step(0, 0, 0, 10, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 40, 0, 1, 1, 0, "R2");
    step(0, 1, 0, 40, 1, 0, 0, 0, "R2");
    step(0, 2, 0, 50, 1, 1, 0, 0, "R2");
    step(0, 3, 0, 25, 1, 1, 0, 0, "R2");
    step(0, 3, 0, 20, 0, 0, 1, 0, "R2");
    // R4: increment wraps 127 -> 0
    step(0, 0, 0, 127, 0, 0, 0, 0, "R3");
    step(0, 2, 0, 5, 0, 0, 0, 0, "R4");
    step(0, 2, 1, 5, 0, 0, 0, 0, "R4");
    // R5 / R6 / R7: call, untaken call, return ignoring fields
    step(0, 0, 1, 90, 0, 0, 0, 0, "R5");
    step(0, 2, 1, 12, 0, 0, 0, 0, "R6");
    step(0, 3, 2, 5, 1, 1, 0, 0, "R7");
    // R9: nested call replaces the first return address
    step(0, 0, 0, 30, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 60, 0, 0, 0, 0, "R5");
    step(0, 1, 1, 70, 1, 0, 0, 0, "R9");
    step(0, 1, 2, 3, 0, 0, 0, 0, "R9");
    // R8 / R10: map ignores fields, pending return survives map and jump
    step(0, 0, 1, 100, 0, 0, 0, 0, "R5");
    step(0, 2, 3, 127, 1, 1, 1, 15, "R8");
    step(0, 1, 3, 44, 0, 0, 0, 5, "R8");
    step(0, 0, 0, 9, 0, 0, 0, 0, "R10");
    step(0, 2, 2, 9, 0, 0, 0, 0, "R10");
    // R5: call from 127 saves 0
    step(0, 0, 0, 127, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 3, 0, 0, 0, 0, "R5");
    step(0, 0, 2, 3, 0, 0, 0, 0, "R5");
    // R1: reset in mid-run clears a pending return
    step(0, 0, 1, 64, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 2, 0, 0, 0, 0, 0, "R1");
    // R2: random field and status patterns
    for (int i = 0; i < 400; i++) begin
      step(0, int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(127)),
           1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
           int'($urandom_range(15)), "R2");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule